// File: doc/BRIEF.md
# DS3 Application-ID Format Detector

This block tells whether a received DS3 stream is in C-bit parity framing or in M23 framing. An upstream framer delivers one application-identification bit per M-frame on `aic_bit` and marks it with a one-cycle strobe on `mf_stb`. That bit is the leading C bit of M-subframe 1. A C-bit parity source keeps it at 1. An M23 source uses it as a stuff-control bit, so it toggles.

The detector splits the strobed frames into back-to-back windows of `WIN_LEN` M-frames. The default is 1024 frames, about 109 ms at the DS3 rate. In each window it counts the frames whose bit was 1. On the last frame of a window it compares that count with `SET_THRESH` (default 1020) and updates `cbit_fmt`, then starts a fresh window. The output is a live status and is not latched. When the line is E3, the output carries no meaning and the consumer ignores it.

A loss-of-frame indication restarts the window. It does not change the output.

Top module: `aic_fmt_detect`

## Requirements
- R1: While `rst_n` is low, `cbit_fmt` is 0 and both the window and the ones tally restart from empty.
- R2: `cbit_fmt` changes only on the clock edge that accepts the last strobed frame of a window. Partway through a window it keeps its previous value.
- R3: When the window's count of frames with `aic_bit` = 1 is `SET_THRESH` or more (including exactly 1020 of 1024), `cbit_fmt` becomes 1 on the edge that accepts the window's last frame.
- R4: When that count is below `SET_THRESH` (including exactly 1019 of 1024, and no ones at all), `cbit_fmt` becomes 0 on that same edge.
- R5: A bit that alternates 1,0,1,0 frame by frame (an M23 stuff-control pattern) gives `cbit_fmt` = 0.
- R6: `aic_bit` is ignored in cycles where `mf_stb` is 0.
- R7: A cycle with `lof` = 1 empties the ones tally and the frame count, so the next accepted frame is frame 1 of a new window. `cbit_fmt` keeps its value through that cycle and up to the end of the new window.
- R8: A strobe in the same cycle as `lof` = 1 is discarded. That frame neither counts nor completes a window.
- R9: Windows are consecutive and do not overlap. The frame after a window's last frame is frame 1 of the next window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lof | input | 1 | Loss-of-frame from the framer; restarts the window |
| mf_stb | input | 1 | One-cycle marker that `aic_bit` holds this M-frame's bit |
| aic_bit | input | 1 | Application-identification bit of the current M-frame |
| cbit_fmt | output | 1 | 1 = C-bit parity format detected, 0 = M23 or undecided |

## Verification
The bench feeds whole windows with these patterns:
- All ones and all zeros, which move the output both ways.
- Exactly 1020 ones and exactly 1019 ones, which pin the threshold comparison to the correct side of the boundary.
- An alternating pattern, the M23 case.

Idle cycles drive `aic_bit` high, so a count that leaked non-strobed cycles would flip the all-zero result. Mid-window probes show the output holding until the boundary.

Two sequences exercise loss of frame:
- Loss of frame partway through a window, followed by 1020 ones. The result would differ if the old window were allowed to finish.
- A strobe that coincides with loss of frame on what would be the 1024th frame. This shows the frame is dropped and not counted.

// File: rtl/aic_fmt_pkg.sv
package aic_fmt_pkg;

   typedef enum logic {
      FMT_M23  = 1'b0,
      FMT_CBIT = 1'b1
   } fmt_e;

   function automatic int tally_width(input int frames);
      return $clog2(frames + 1);
   endfunction

   function automatic int index_width(input int frames);
      return $clog2(frames);
   endfunction

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/aic_frame_ctr.sv
module aic_frame_ctr #(
   parameter int WIN_LEN = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic stb,
   output logic win_last
);
   import aic_fmt_pkg::*;

   localparam int FRM_W = index_width(WIN_LEN);
   localparam logic [FRM_W-1:0] LAST_IDX = FRM_W'(WIN_LEN - 1);

   logic [FRM_W-1:0] idx_q;

   assign win_last = stb && (idx_q == LAST_IDX);

   generate
      if (is_pow2(WIN_LEN)) begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      idx_q <= '0;
            else if (clr)    idx_q <= '0;
            else if (stb)    idx_q <= idx_q + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        idx_q <= '0;
            else if (clr)      idx_q <= '0;
            else if (win_last) idx_q <= '0;
            else if (stb)      idx_q <= idx_q + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/aic_ones_ctr.sv
module aic_ones_ctr #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             stb,
   input  logic             bit_in,
   input  logic             win_last,
   output logic [CNT_W-1:0] tally_incl
);
   logic [CNT_W-1:0] tally_q;

   assign tally_incl = tally_q + CNT_W'(stb & bit_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tally_q <= '0;
      else if (clr)      tally_q <= '0;
      else if (win_last) tally_q <= '0;
      else if (stb)      tally_q <= tally_incl;
   end

endmodule

// File: rtl/aic_thresh_cmp.sv
module aic_thresh_cmp #(
   parameter int CNT_W      = 11,
   parameter int SET_THRESH = 1020
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             win_last,
   input  logic [CNT_W-1:0] tally,
   output logic             fmt
);
   import aic_fmt_pkg::*;

   localparam logic [CNT_W-1:0] THR = CNT_W'(SET_THRESH);

   fmt_e verdict;
   fmt_e state_q;

   assign verdict = (tally >= THR) ? FMT_CBIT : FMT_M23;
   assign fmt     = (state_q == FMT_CBIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        state_q <= FMT_M23;
      else if (win_last) state_q <= verdict;
   end

endmodule

// File: rtl/aic_fmt_detect.sv
module aic_fmt_detect #(
   parameter int WIN_LEN    = 1024,
   parameter int SET_THRESH = 1020
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lof,
   input  logic mf_stb,
   input  logic aic_bit,
   output logic cbit_fmt
);
   import aic_fmt_pkg::*;

   localparam int CNT_W = tally_width(WIN_LEN);

   generate
      if (WIN_LEN < 2) begin : g_bad_len
         $error("aic_fmt_detect: WIN_LEN must be at least 2");
      end
      if (SET_THRESH < 1 || SET_THRESH > WIN_LEN) begin : g_bad_thr
         $error("aic_fmt_detect: SET_THRESH must lie in 1..WIN_LEN");
      end
   endgenerate

   logic             stb_ok;
   logic             win_last;
   logic [CNT_W-1:0] tally;

   assign stb_ok = mf_stb & ~lof;

   aic_frame_ctr #(.WIN_LEN(WIN_LEN)) frm_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (lof),
      .stb      (stb_ok),
      .win_last (win_last)
   );

   aic_ones_ctr #(.CNT_W(CNT_W)) ones_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (lof),
      .stb        (stb_ok),
      .bit_in     (aic_bit),
      .win_last   (win_last),
      .tally_incl (tally)
   );

   aic_thresh_cmp #(.CNT_W(CNT_W), .SET_THRESH(SET_THRESH)) cmp_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .win_last (win_last),
      .tally    (tally),
      .fmt      (cbit_fmt)
   );

endmodule

// File: rtl/aic_fmt_detect_chk.sv
module aic_fmt_detect_chk #(
   parameter int WIN_LEN    = 1024,
   parameter int SET_THRESH = 1020
) (
   input logic clk,
   input logic rst_n,
   input logic lof,
   input logic mf_stb,
   input logic aic_bit,
   input logic cbit_fmt
);
   int unsigned seen_q;
   int unsigned ones_q;
   logic        acc;
   logic        at_end;
   int unsigned total;

   assign acc    = mf_stb && !lof;
   assign at_end = acc && (seen_q == WIN_LEN - 1);
   assign total  = ones_q + (aic_bit ? 1 : 0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 0;
         ones_q <= 0;
      end else if (lof || at_end) begin
         seen_q <= 0;
         ones_q <= 0;
      end else if (acc) begin
         seen_q <= seen_q + 1;
         ones_q <= total;
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_clear_R1: assert (cbit_fmt == 1'b0)
            else $error("R1: output not cleared in reset");
      end
   end

   assert_only_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cbit_fmt) |-> $past(at_end))
      else $error("R2: output moved away from window end");

   assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (at_end && total >= SET_THRESH) |=> cbit_fmt)
      else $error("R3: output not set");

   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (at_end && total < SET_THRESH) |=> !cbit_fmt)
      else $error("R4: output not cleared");

   assert_lof_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lof |=> $stable(cbit_fmt))
      else $error("R7: output moved on loss of frame");

endmodule

bind aic_fmt_detect aic_fmt_detect_chk #(
   .WIN_LEN    (WIN_LEN),
   .SET_THRESH (SET_THRESH)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .lof      (lof),
   .mf_stb   (mf_stb),
   .aic_bit  (aic_bit),
   .cbit_fmt (cbit_fmt)
);

// File: tb/aic_fmt_detect_tb_top.sv
module aic_fmt_detect_tb_top;

   localparam int WIN  = 1024;
   localparam int THR  = 1020;
   localparam int WDOG = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lof = 1'b0;
   logic mf_stb = 1'b0;
   logic aic_bit = 1'b0;
   logic cbit_fmt;

   int total_chk = 0;
   int bad_chk = 0;
   int cyc = 0;
   bit done = 1'b0;

   logic  exp_q[$];
   string tag_q[$];

   always #10 clk = ~clk;

   aic_fmt_detect #(.WIN_LEN(WIN), .SET_THRESH(THR)) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .lof      (lof),
      .mf_stb   (mf_stb),
      .aic_bit  (aic_bit),
      .cbit_fmt (cbit_fmt)
   );

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
      $finish;
   endtask

   // Scoreboard monitor: compares the oldest expected item at each falling edge.
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic  e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         total_chk++;
         if (cbit_fmt !== e) begin
            bad_chk++;
            $display("FAIL %s: cbit_fmt actual=%0b expected=%0b", t, cbit_fmt, e);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > WDOG && !done) begin
         bad_chk++;
         total_chk++;
         $display("FAIL watchdog: run hung actual=%0d expected<=%0d cycles", cyc, WDOG);
         finish_run();
      end
   end

   task automatic expect_fmt(input logic v, input string t);
      exp_q.push_back(v);
      tag_q.push_back(t);
   endtask

   // One M-frame: strobe cycle, then an idle cycle with aic_bit forced high (R6).
   task automatic frame(input logic b, input logic with_lof = 1'b0);
      @(negedge clk);
      mf_stb  = 1'b1;
      aic_bit = b;
      lof     = with_lof;
      @(negedge clk);
      mf_stb  = 1'b0;
      lof     = 1'b0;
      aic_bit = 1'b1;
   endtask

   task automatic frames(input int n, input logic b);
      for (int i = 0; i < n; i++) frame(b);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      expect_fmt(1'b0, "R1 reset value");
      @(negedge clk);
      rst_n = 1'b1;

      // All ones -> set (R3, R9 first window)
      frames(WIN, 1'b1);
      expect_fmt(1'b1, "R3 all ones window");

      // All zeros with high idle bits (R6, R2, R4)
      frames(WIN / 2, 1'b0);
      expect_fmt(1'b1, "R2 held mid-window");
      frames(WIN / 2, 1'b0);
      expect_fmt(1'b0, "R4/R6 all zeros, idle ones ignored");

      // Exactly threshold -> set (R3 boundary, R9 next window)
      frames(THR, 1'b1);
      frames(WIN - THR, 1'b0);
      expect_fmt(1'b1, "R3/R9 exactly 1020 ones");

      // One short of threshold -> clear (R4 boundary)
      frames(THR - 1, 1'b1);
      expect_fmt(1'b1, "R2 held before boundary");
      frames(WIN - THR + 1, 1'b0);
      expect_fmt(1'b0, "R4 exactly 1019 ones");

      // Alternating stuff-control pattern -> set first then clear (R5)
      frames(WIN, 1'b1);
      expect_fmt(1'b1, "R3 re-set before toggle");
      for (int i = 0; i < WIN; i++) frame(logic'(i % 2 == 0));
      expect_fmt(1'b0, "R5 alternating pattern");

      // Strobe together with lof is dropped (R8)
      frames(WIN - 1, 1'b1);
      frame(1'b1, 1'b1);
      expect_fmt(1'b0, "R8 strobe with lof discarded");
      frames(WIN - 1, 1'b1);
      expect_fmt(1'b0, "R8 no window end one frame early");
      frame(1'b1);
      expect_fmt(1'b1, "R8/R7 fresh window completes");

      // Loss of frame mid-window restarts it, output held (R7)
      frames(600, 1'b0);
      @(negedge clk);
      lof = 1'b1;
      @(negedge clk);
      lof = 1'b0;
      expect_fmt(1'b1, "R7 held through lof");
      frames(WIN - 600, 1'b1);
      expect_fmt(1'b1, "R7 old window did not end");
      frames(THR - (WIN - 600), 1'b1);
      frames(WIN - THR, 1'b0);
      expect_fmt(1'b1, "R7 restarted window result");

      repeat (4) @(negedge clk);
      done = 1'b1;
      finish_run();
   end

endmodule